// File: doc/BRIEF.md
# Shared-Multiplier Six-Axis PID Engine

This block runs six independent PID controllers, one for each degree of freedom (three translations and three rotations), on a single signed multiplier that is 25 bits by 18 bits. A one-cycle `start` pulse captures the setpoints and the feedback values. The block then feeds one operand pair per clock into the multiplier, five pairs for each axis. Each product returns after the pipeline latency together with a tag that names its axis and its term. The tag steers the product into the correct sum and the correct state register.

For each axis the five products are: proportional, integral increment, derivative of the error difference, derivative filter feedback, and setpoint feedforward. Each product is rescaled to a fixed Q format and saturated, so the width does not grow from one stage to the next. When all six efforts are valid, `done` rises for one cycle. A full update takes 33 clocks, which is a small fraction of a 20 kHz control period at any practical clock rate.

Top module: `mpid_engine`

## Requirements
- R1: After reset all efforts read 0 and `done` is low. The integrator, previous-error and derivative-filter states of every channel are 0.
- R2: For each channel the error is e = sp − fb, computed as a 17-bit signed value. S(x) means x shifted arithmetically right by 12 bits and then saturated to 25-bit signed. The proportional part is P = S(kp·e).
- R3: Each channel's integrator updates as I = clamp(sat25(I + S(ki·e)), −lim, +lim), where lim is the unsigned `int_lim` input. The new I is used in the current update.
- R4: Each channel's derivative state updates as D = sat25(S(kd·(e − e_prev)) + S(kf·D_old)). Here e_prev is that channel's error from the previous update and D_old is the previous D.
- R5: The feedforward part of each channel is S(kff·sp).
- R6: The effort is P + I + D + FF. Each partial sum is saturated to 25-bit signed, and the final value is saturated to 16-bit signed (−32768..32767).
- R7: `done` is high for exactly one cycle. It is first seen high 33 clocks (5·6 issue slots + 3 pipeline stages) after the rising edge that captured `start`. The efforts are valid from that cycle on.
- R8: A `start` that arrives while an update is in progress has no effect: the running update keeps its captured inputs, and no extra `done` is produced.
- R9: While the block is issuing, exactly one operand pair enters the multiplier per clock. Results return in channel-major, term-minor order: P, I, D, D-filter, FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one six-axis update |
| sp_in | input | 96 | Setpoints, 16-bit signed, channel c at [16c+15:16c] |
| fb_in | input | 96 | Feedback, 16-bit signed, same packing |
| kp_in | input | 108 | Proportional gains, 18-bit signed Q12, channel c at [18c+17:18c] |
| ki_in | input | 108 | Integral gains, same format |
| kd_in | input | 108 | Derivative gains, same format |
| kf_in | input | 108 | Derivative filter gains, same format |
| kff_in | input | 108 | Feedforward gains, same format |
| int_lim | input | 24 | Integrator magnitude limit, unsigned |
| effort_out | output | 96 | Control efforts, 16-bit signed, same packing as sp_in |
| done | output | 1 | One-cycle strobe when all efforts are valid |

## Verification
The assertions check on every cycle that the product tags come back in strict order. They also check that the integrator never leaves its limit after a write, that `done` lasts one cycle and follows the final write-back, and that a `start` during a run leaves the captured inputs untouched. The numeric results need the bench's scenarios: a bench-side model of the saturating arithmetic is stepped across a vector table that carries state from one update to the next. Directed runs cover integrator windup, output saturation at both rails, the 33-cycle latency, and a second `start` with changed inputs in the middle of a run.

// File: rtl/mpid_engine.sv
module mpid_engine #(
  parameter int NCH  = 6,
  parameter int DW   = 16,
  parameter int GW   = 18,
  parameter int AW   = 25,
  parameter int OW   = 16,
  parameter int FRAC = 12,
  parameter int LAT  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NCH*DW-1:0]   sp_in,
  input  logic [NCH*DW-1:0]   fb_in,
  input  logic [NCH*GW-1:0]   kp_in,
  input  logic [NCH*GW-1:0]   ki_in,
  input  logic [NCH*GW-1:0]   kd_in,
  input  logic [NCH*GW-1:0]   kf_in,
  input  logic [NCH*GW-1:0]   kff_in,
  input  logic [AW-2:0]       int_lim,
  output logic [NCH*OW-1:0]   effort_out,
  output logic                done
);

  localparam int NT = 5;
  localparam int EW = DW + 1;
  localparam int PW = AW + GW;
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TW = 3;
  localparam longint AHI = (64'sd1 <<< (AW - 1)) - 64'sd1;
  localparam longint OHI = (64'sd1 <<< (OW - 1)) - 64'sd1;
  localparam logic signed [PW-1:0] P_HI = PW'(AHI);
  localparam logic signed [PW-1:0] P_LO = -P_HI - 1;
  localparam logic signed [AW:0]   S_HI = (AW+1)'(AHI);
  localparam logic signed [AW:0]   S_LO = -S_HI - 1;
  localparam logic signed [AW-1:0] A_HI = AW'(AHI);
  localparam logic signed [AW-1:0] A_LO = -A_HI - 1;
  localparam logic signed [AW-1:0] O_HI = AW'(OHI);
  localparam logic signed [AW-1:0] O_LO = -O_HI - 1;
  localparam logic [TW-1:0] T_P = 3'd0, T_I = 3'd1, T_D = 3'd2, T_F = 3'd3, T_FF = 3'd4;

  function automatic logic signed [AW-1:0] clip_p(input logic signed [PW-1:0] x);
    if (x > P_HI) return A_HI;
    if (x < P_LO) return A_LO;
    return x[AW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] add_s(input logic signed [AW-1:0] a,
                                                 input logic signed [AW-1:0] b);
    logic signed [AW:0] s;
    s = $signed({a[AW-1], a}) + $signed({b[AW-1], b});
    if (s > S_HI) return A_HI;
    if (s < S_LO) return A_LO;
    return s[AW-1:0];
  endfunction

  function automatic logic [OW-1:0] clip_o(input logic signed [AW-1:0] x);
    if (x > O_HI) return O_HI[OW-1:0];
    if (x < O_LO) return O_LO[OW-1:0];
    return x[OW-1:0];
  endfunction

  logic                   busy, issuing;
  logic [CW-1:0]          iss_ch;
  logic [TW-1:0]          iss_tm;
  logic signed [EW-1:0]   e_cur [NCH];
  logic signed [EW-1:0]   e_prv [NCH];
  logic signed [DW-1:0]   sp_l  [NCH];
  logic signed [AW-1:0]   integ [NCH];
  logic signed [AW-1:0]   dfilt [NCH];
  logic [OW-1:0]          effort_r [NCH];
  logic signed [AW-1:0]   acc, dpart;

  wire accept = start && !busy;

  // operand selection for the issue slot
  logic signed [EW-1:0] ec, ep;
  logic signed [EW:0]   dif;
  logic signed [AW-1:0] a_mux;
  logic signed [GW-1:0] b_mux;

  assign ec  = e_cur[iss_ch];
  assign ep  = e_prv[iss_ch];
  assign dif = $signed({ec[EW-1], ec}) - $signed({ep[EW-1], ep});

  always_comb begin
    case (iss_tm)
      T_P: begin
        a_mux = {{(AW-EW){ec[EW-1]}}, ec};
        b_mux = kp_in[iss_ch*GW +: GW];
      end
      T_I: begin
        a_mux = {{(AW-EW){ec[EW-1]}}, ec};
        b_mux = ki_in[iss_ch*GW +: GW];
      end
      T_D: begin
        a_mux = {{(AW-EW-1){dif[EW]}}, dif};
        b_mux = kd_in[iss_ch*GW +: GW];
      end
      T_F: begin
        a_mux = dfilt[iss_ch];
        b_mux = kf_in[iss_ch*GW +: GW];
      end
      default: begin
        a_mux = {{(AW-DW){sp_l[iss_ch][DW-1]}}, sp_l[iss_ch]};
        b_mux = kff_in[iss_ch*GW +: GW];
      end
    endcase
  end

  // issue sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing <= 1'b0;
      iss_ch  <= '0;
      iss_tm  <= '0;
    end else if (accept) begin
      issuing <= 1'b1;
      iss_ch  <= '0;
      iss_tm  <= '0;
    end else if (issuing) begin
      if (iss_tm == T_FF) begin
        iss_tm <= '0;
        if (iss_ch == CW'(NCH - 1)) issuing <= 1'b0;
        else                        iss_ch  <= iss_ch + 1'b1;
      end else begin
        iss_tm <= iss_tm + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        e_cur[c] <= '0;
        sp_l[c]  <= '0;
      end
    end else if (accept) begin
      for (int c = 0; c < NCH; c++) begin
        e_cur[c] <= $signed({sp_in[c*DW+DW-1], sp_in[c*DW +: DW]})
                  - $signed({fb_in[c*DW+DW-1], fb_in[c*DW +: DW]});
        sp_l[c]  <= sp_in[c*DW +: DW];
      end
    end
  end

  // multiplier pipeline with matching tag pipeline
  logic signed [AW-1:0] op_a;
  logic signed [GW-1:0] op_b;
  logic signed [PW-1:0] prod [LAT-1];
  logic [LAT-1:0]       v_p;
  logic [CW-1:0]        ch_p [LAT];
  logic [TW-1:0]        tm_p [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a <= '0;
      op_b <= '0;
      v_p  <= '0;
      for (int i = 0; i < LAT; i++) begin
        ch_p[i] <= '0;
        tm_p[i] <= '0;
      end
      for (int i = 0; i < LAT - 1; i++) prod[i] <= '0;
    end else begin
      op_a    <= issuing ? a_mux : '0;
      op_b    <= issuing ? b_mux : '0;
      v_p[0]  <= issuing;
      ch_p[0] <= iss_ch;
      tm_p[0] <= iss_tm;
      prod[0] <= PW'(op_a) * PW'(op_b);
      for (int i = 1; i < LAT - 1; i++) prod[i] <= prod[i-1];
      for (int i = 1; i < LAT; i++) begin
        v_p[i]  <= v_p[i-1];
        ch_p[i] <= ch_p[i-1];
        tm_p[i] <= tm_p[i-1];
      end
    end
  end

  // write-back
  wire                   wb_v  = v_p[LAT-1];
  wire [CW-1:0]          wb_ch = ch_p[LAT-1];
  wire [TW-1:0]          wb_tm = tm_p[LAT-1];
  wire signed [PW-1:0]   wb_sh = prod[LAT-2] >>> FRAC;
  wire signed [AW-1:0]   scaled = clip_p(wb_sh);
  wire signed [AW-1:0]   lim_s  = $signed({1'b0, int_lim});
  wire signed [AW-1:0]   i_sum  = add_s(integ[wb_ch], scaled);
  wire signed [AW-1:0]   i_new  = (i_sum > lim_s) ? lim_s : (i_sum < -lim_s) ? -lim_s : i_sum;
  wire signed [AW-1:0]   d_new  = add_s(dpart, scaled);
  wire signed [AW-1:0]   fin    = add_s(acc, scaled);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      acc   <= '0;
      dpart <= '0;
      for (int c = 0; c < NCH; c++) begin
        integ[c]    <= '0;
        dfilt[c]    <= '0;
        e_prv[c]    <= '0;
        effort_r[c] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (accept) busy <= 1'b1;
      if (wb_v) begin
        case (wb_tm)
          T_P: acc <= scaled;
          T_I: begin
            integ[wb_ch] <= i_new;
            acc          <= add_s(acc, i_new);
          end
          T_D: dpart <= scaled;
          T_F: begin
            dfilt[wb_ch] <= d_new;
            acc          <= add_s(acc, d_new);
          end
          default: begin
            effort_r[wb_ch] <= clip_o(fin);
            e_prv[wb_ch]    <= e_cur[wb_ch];
            if (wb_ch == CW'(NCH - 1)) begin
              done <= 1'b1;
              busy <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign effort_out[c*OW +: OW] = effort_r[c];

    p_int_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_v && wb_tm == T_I && wb_ch == CW'(c)) |=>
        (integ[c] <= $past(lim_s)) && (integ[c] >= -$past(lim_s)));
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wb_v && wb_ch == CW'(NCH - 1) && wb_tm == T_FF));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(sp_l[0]) && $stable(e_cur[0]));

  p_tag_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_v && wb_tm != T_FF) |=>
      (wb_v && wb_ch == $past(wb_ch) && wb_tm == $past(wb_tm) + 1'b1));

  p_issue_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (v_p[0] && tm_p[0] != T_FF) |=> v_p[0]);

endmodule

// File: tb/mpid_engine_tb.sv
module mpid_engine_tb;
  localparam int NCH = 6;
  localparam int NV  = 8;
  localparam int LATENCY = 33;

  localparam int VSP [NV] = '{1000, -2000, 5000, 0, 32767, -32768, 12345, -500};
  localparam int VFB [NV] = '{0, 1500, 4000, 3000, -32768, 32767, 12000, 500};

  logic clk = 0, rst_n = 0, start = 0;
  logic [NCH*16-1:0] sp_in, fb_in, effort_out;
  logic [NCH*18-1:0] kp_in, ki_in, kd_in, kf_in, kff_in;
  logic [23:0] int_lim;
  logic done;

  int sp_v [NCH], fb_v [NCH], kp [NCH], ki [NCH], kd [NCH], kf [NCH], kff [NCH];
  int lim;
  longint m_int [NCH], m_ep [NCH], m_df [NCH], m_out [NCH];
  int n_chk = 0, n_bad = 0, n_done = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sp_in[c*16 +: 16]  = 16'(sp_v[c]);
      fb_in[c*16 +: 16]  = 16'(fb_v[c]);
      kp_in[c*18 +: 18]  = 18'(kp[c]);
      ki_in[c*18 +: 18]  = 18'(ki[c]);
      kd_in[c*18 +: 18]  = 18'(kd[c]);
      kf_in[c*18 +: 18]  = 18'(kf[c]);
      kff_in[c*18 +: 18] = 18'(kff[c]);
    end
    int_lim = 24'(lim);
  end

  always @(negedge clk) if (rst_n && done) n_done++;

  mpid_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sp_in(sp_in), .fb_in(fb_in),
    .kp_in(kp_in), .ki_in(ki_in), .kd_in(kd_in), .kf_in(kf_in), .kff_in(kff_in),
    .int_lim(int_lim), .effort_out(effort_out), .done(done)
  );

  function automatic longint sat(longint x, int bits);
    longint hi = (64'sd1 <<< (bits - 1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  function automatic longint sc(longint x);
    return sat(x >>> 12, 25);
  endfunction

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      longint e, acc, ni, dn;
      e   = longint'(sp_v[c]) - longint'(fb_v[c]);
      acc = sc(kp[c] * e);
      ni  = sat(m_int[c] + sc(ki[c] * e), 25);
      if (ni > lim) ni = lim;
      if (ni < -lim) ni = -lim;
      m_int[c] = ni;
      acc = sat(acc + ni, 25);
      dn  = sat(sc(kd[c] * (e - m_ep[c])) + sc(kf[c] * m_df[c]), 25);
      m_df[c] = dn;
      acc = sat(acc + dn, 25);
      acc = sat(acc + sc(kff[c] * longint'(sp_v[c])), 25);
      m_out[c] = sat(acc, 16);
      m_ep[c] = e;
    end
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint eff(int c);
    return longint'($signed(effort_out[c*16 +: 16]));
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_int[c] = 0; m_ep[c] = 0; m_df[c] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  // pulse start, return cycles until done is seen
  task automatic kick(output int lat);
    @(negedge clk); start = 1;
    @(posedge clk); #1 start = 0;
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk); #1 lat++;
    end
  endtask

  task automatic run_check(string req);
    int lat;
    model_step();
    kick(lat);
    chk("R7 latency", lat, LATENCY);
    for (int c = 0; c < NCH; c++) chk(req, eff(c), m_out[c]);
    @(posedge clk); #1 chk("R7 single pulse", done, 0);
  endtask

  task automatic table_gains();
    for (int c = 0; c < NCH; c++) begin
      kp[c] = 4096 + c * 700; ki[c] = 300 + c * 50; kd[c] = 2000;
      kf[c] = 1024 + c * 256; kff[c] = 64 * c;
    end
    lim = 200000;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      sp_v[c] = 0; fb_v[c] = 0;
    end
    table_gains();
    do_reset();

    // R1: reset state
    chk("R1 done", done, 0);
    for (int c = 0; c < NCH; c++) chk("R1 effort", eff(c), 0);

    // vector table: state (integrator, previous error, filter) carries over
    for (int i = 0; i < NV; i++) begin
      for (int c = 0; c < NCH; c++) begin
        sp_v[c] = int'(sat(VSP[i] + c * 37, 16));
        fb_v[c] = int'(sat(VFB[i] - c * 19, 16));
      end
      run_check("R2 R3 R4 R5 R6 table");
    end

    // R1: state cleared by reset -> first update equals fresh model
    do_reset();
    for (int c = 0; c < NCH; c++) chk("R1 effort after reset", eff(c), 0);
    for (int c = 0; c < NCH; c++) begin
      sp_v[c] = 800; fb_v[c] = 100 * c;
    end
    run_check("R1 R4 fresh state");

    // R2: proportional only, exact values
    do_reset();
    for (int c = 0; c < NCH; c++) begin
      kp[c] = 8192; ki[c] = 0; kd[c] = 0; kf[c] = 0; kff[c] = 0;
      sp_v[c] = 1000 * c; fb_v[c] = -500;
    end
    run_check("R2 proportional");
    chk("R2 gain two", eff(2), 2 * 2500);

    // R3: integrator windup clamp
    do_reset();
    lim = 5000;
    for (int c = 0; c < NCH; c++) begin
      kp[c] = 0; ki[c] = 4096; kd[c] = 0; kf[c] = 0; kff[c] = 0;
      sp_v[c] = (c % 2) ? -3000 : 3000; fb_v[c] = 0;
    end
    for (int k = 0; k < 3; k++) run_check("R3 windup");
    chk("R3 clamp high", eff(0), 5000);
    chk("R3 clamp low", eff(1), -5000);

    // R5: feedforward only
    do_reset();
    for (int c = 0; c < NCH; c++) begin
      ki[c] = 0; kff[c] = 2048; sp_v[c] = 600 - 300 * c; fb_v[c] = 7;
    end
    run_check("R5 feedforward");
    chk("R5 half of setpoint", eff(1), 150);

    // R6: saturation at both rails
    do_reset();
    for (int c = 0; c < NCH; c++) begin
      kp[c] = 131071; kff[c] = 0;
      sp_v[c] = (c < 3) ? 32767 : -32768; fb_v[c] = (c < 3) ? -32768 : 32767;
    end
    run_check("R6 saturation");
    chk("R6 top rail", eff(0), 32767);
    chk("R6 bottom rail", eff(5), -32768);

    // R8: start during an update is ignored
    do_reset();
    table_gains();
    for (int c = 0; c < NCH; c++) begin
      sp_v[c] = 1500 + c; fb_v[c] = 200;
    end
    begin
      int lat;
      model_step();
      n_done = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        sp_v[c] = -9000; fb_v[c] = 9000;
      end
      start = 1;
      @(negedge clk); start = 0;
      lat = 0;
      while (!done && lat < 200) begin
        @(negedge clk); lat++;
      end
      for (int c = 0; c < NCH; c++) chk("R8 captured inputs kept", eff(c), m_out[c]);
      repeat (45) @(negedge clk);
      chk("R8 one done only", n_done, 1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule